// File: doc/BRIEF.md
# Split-Screen Display Address Generator

This block produces the linear display-memory address for a raster video controller whose screen can be divided into an upper and a lower region. The upper region starts every frame at a programmable 16-bit start address. When the scan-line count reaches a programmable split line, the address generator and its row-base latch are cleared, so the lower region always shows memory starting from address 0. Moving the start address therefore scrolls only the upper region.

Inside a row the address steps by one on each character clock that carries active display, and it holds during blanking. At every line end the next row base is the old base plus a row offset, modulo 2^16. The block also supplies the effective horizontal pan value. If pan-lock is enabled, the pan value is forced to zero from the split until the next frame start, so that panning the upper region leaves the lower region still. The split line is captured at frame start. Software can therefore rewrite it at any time, and writes made during vertical retrace move the lower region smoothly from frame to frame.

Top module: `split_scan_addr`

## Requirements
- R1: While reset is held, and in the first cycle after it, mem_addr is 0, lower_active is 0 and pan_out equals pan_in.
- R2: A frame_start strobe (one cycle) sets the line count to 0. On the next cycle mem_addr equals the start_addr value present at the strobe, and lower_active is 0, unless the captured split line is 0. frame_start takes priority over line_end and disp_en.
- R3: In a cycle with disp_en=1 and no strobe, mem_addr increments by 1 on the next cycle, wrapping from 0xFFFF to 0x0000. With disp_en=0 and no strobe it holds.
- R4: A line_end strobe (one cycle) loads mem_addr and the row base with (row base + row_offset) mod 2^16, unless that line end triggers the split. line_end takes priority over disp_en.
- R5: The line count increases by one on each line_end. When the new count equals the captured split line, mem_addr and the row base become 0 and lower_active becomes 1 on the next cycle. lower_active stays 1 until the next frame_start.
- R6: A captured split line of 0 makes the whole frame the lower region: after frame_start, mem_addr is 0 and lower_active is 1.
- R7: A split line larger than the number of lines in the frame never triggers, so lower_active stays 0 for the whole frame.
- R8: With pan_lock=1 at the moment of the split, pan_out is 0 from the cycle after the split until the cycle after the next frame_start. With pan_lock=0, pan_out always equals pan_in.
- R9: Writes to split_line or start_addr between two frame_start strobes do not change the current frame. The values take effect at the next frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe at the start of vertical sync |
| line_end | input | 1 | One-cycle strobe at the end of each scan line |
| disp_en | input | 1 | High on character clocks of active display |
| start_addr | input | 16 | Start address of the upper region |
| row_offset | input | 16 | Address step between rows |
| split_line | input | LINE_W | Scan line at which the lower region begins |
| pan_in | input | PAN_W | Programmed horizontal pan value |
| pan_lock | input | 1 | Force pan to zero in the lower region |
| mem_addr | output | 16 | Current display-memory address |
| pan_out | output | PAN_W | Effective horizontal pan value |
| lower_active | output | 1 | High while the lower region is displayed |

## Verification
Every result is registered, so mem_addr, lower_active and the pan lock all change on the single clock edge that consumes the strobe or display-enable cycle. pan_out follows pan_in combinationally, and its lock follows one edge later. The bench changes inputs on falling edges and checks results on the next falling edge, half a cycle after the edge that produced them. Each expected address is computed by a frame model in the bench that steps the row base, the split and the 16-bit wrap along the same strobe sequence the bench applies.

// File: rtl/split_pkg.sv
// Package split_pkg: shared widths and types for the split-screen address generator.
// Assumes the display memory is addressed by a fixed 16-bit linear address.
package split_pkg;
    localparam int ADDR_W = 16;
    typedef logic [ADDR_W-1:0] vaddr_t;
endpackage

// File: rtl/split_line_cmp.sv
// split_line_cmp: scan-line counter, frame-captured split line and region flag.
// Assumes frame_start and line_end are single-cycle strobes; frame_start wins.
module split_line_cmp #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_end,
    input  logic [LINE_W-1:0] split_line,
    output logic              split_hit,
    output logic              lower_active
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] split_sh;
    logic [LINE_W-1:0] next_line;

    // Next line number, saturating so a wrap can never re-trigger the split.
    always_comb begin
        next_line = (line_cnt == LINE_MAX) ? line_cnt : line_cnt + 1'b1;
    end

    // Split request: line 0 at frame start, or a match on entering a new line.
    always_comb begin
        if (frame_start)
            split_hit = (split_line == '0);
        else
            split_hit = line_end && !lower_active && (next_line == split_sh);
    end

    // Line counter and split-line capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
            split_sh <= '0;
        end else if (frame_start) begin
            line_cnt <= '0;
            split_sh <= split_line;
        end else if (line_end) begin
            line_cnt <= next_line;
        end
    end

    // Region flag: set by the split, cleared only at the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lower_active <= 1'b0;
        else if (frame_start)
            lower_active <= split_hit;
        else if (split_hit)
            lower_active <= 1'b1;
    end

    // R5: once in the lower region, stay there until the next frame
    p_lower_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lower_active && !frame_start) |=> lower_active);

    // R9: the captured split line does not move inside a frame
    p_split_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(split_sh));
endmodule

// File: rtl/split_row_addr.sv
// split_row_addr: row-base latch and linear address counter.
// Assumes split_hit arrives in the same cycle as the strobe that causes it.
module split_row_addr
    import split_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_start,
    input  logic   line_end,
    input  logic   disp_en,
    input  logic   split_hit,
    input  vaddr_t start_addr,
    input  vaddr_t row_offset,
    output vaddr_t mem_addr
);
    vaddr_t row_base;
    vaddr_t next_base;

    // Next row base, 16-bit wrapping sum of latch and offset.
    always_comb begin
        next_base = row_base + row_offset;
    end

    // Row-base latch and address counter, priority: split, frame, line, char.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_base <= '0;
            mem_addr <= '0;
        end else if (split_hit) begin
            row_base <= '0;
            mem_addr <= '0;
        end else if (frame_start) begin
            row_base <= start_addr;
            mem_addr <= start_addr;
        end else if (line_end) begin
            row_base <= next_base;
            mem_addr <= next_base;
        end else if (disp_en) begin
            mem_addr <= mem_addr + 1'b1;
        end
    end

    // R3: one step per active character
    p_char_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && !line_end && !frame_start) |=> mem_addr == $past(mem_addr) + 1'b1);

    // R3: hold during blanking
    p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_en && !line_end && !frame_start) |=> $stable(mem_addr));

    // R5: a split clears the address
    p_split_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        split_hit |=> mem_addr == '0);
endmodule

// File: rtl/split_pan_ctl.sv
// split_pan_ctl: forces the pan output to zero in the lower region when locked.
// Assumes pan_lock is sampled at the split and the lock lasts until frame start.
module split_pan_ctl #(
    parameter int PAN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             split_hit,
    input  logic             pan_lock,
    input  logic [PAN_W-1:0] pan_in,
    output logic [PAN_W-1:0] pan_out
);
    logic frozen;

    // Lock flag: armed by a locked split, released at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frozen <= 1'b0;
        else if (frame_start)
            frozen <= split_hit && pan_lock;
        else if (split_hit && pan_lock)
            frozen <= 1'b1;
    end

    // Effective pan value.
    always_comb begin
        pan_out = frozen ? '0 : pan_in;
    end

    // R8: a locked split zeroes the pan output on the next cycle
    p_lock_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (split_hit && pan_lock) |=> pan_out == '0);

    // R8: a frame start without a split restores the programmed pan
    p_frame_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !split_hit) |=> pan_out == pan_in);
endmodule

// File: rtl/split_scan_addr.sv
// split_scan_addr: top of the split-screen display address generator.
// Assumes one-cycle frame_start/line_end strobes from an external timing unit.
module split_scan_addr
    import split_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int PAN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_end,
    input  logic              disp_en,
    input  logic [15:0]       start_addr,
    input  logic [15:0]       row_offset,
    input  logic [LINE_W-1:0] split_line,
    input  logic [PAN_W-1:0]  pan_in,
    input  logic              pan_lock,
    output logic [15:0]       mem_addr,
    output logic [PAN_W-1:0]  pan_out,
    output logic              lower_active
);
    logic split_hit;

    split_line_cmp #(.LINE_W(LINE_W)) u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .line_end     (line_end),
        .split_line   (split_line),
        .split_hit    (split_hit),
        .lower_active (lower_active)
    );

    split_row_addr u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_end    (line_end),
        .disp_en     (disp_en),
        .split_hit   (split_hit),
        .start_addr  (start_addr),
        .row_offset  (row_offset),
        .mem_addr    (mem_addr)
    );

    split_pan_ctl #(.PAN_W(PAN_W)) u_pan (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .split_hit   (split_hit),
        .pan_lock    (pan_lock),
        .pan_in      (pan_in),
        .pan_out     (pan_out)
    );

    // R2: a frame start with a nonzero split line opens the upper region
    p_frame_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && split_line != '0) |=> (mem_addr == $past(start_addr) && !lower_active));

    // R6: a zero split line opens the lower region at address 0
    p_split_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && split_line == '0) |=> (mem_addr == '0 && lower_active));
endmodule

// File: tb/split_scan_addr_tb_top.sv
`timescale 1ns/1ps
module split_scan_addr_tb_top;
    localparam int LINE_W = 11;
    localparam int PAN_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic              line_end = 1'b0;
    logic              disp_en = 1'b0;
    logic [15:0]       start_addr = '0;
    logic [15:0]       row_offset = '0;
    logic [LINE_W-1:0] split_line = '0;
    logic [PAN_W-1:0]  pan_in = 4'd5;
    logic              pan_lock = 1'b0;
    logic [15:0]       mem_addr;
    logic [PAN_W-1:0]  pan_out;
    logic              lower_active;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    split_scan_addr #(.LINE_W(LINE_W), .PAN_W(PAN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_end(line_end),
        .disp_en(disp_en), .start_addr(start_addr), .row_offset(row_offset),
        .split_line(split_line), .pan_in(pan_in), .pan_lock(pan_lock),
        .mem_addr(mem_addr), .pan_out(pan_out), .lower_active(lower_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Frame with model; late_write rewrites split/start after line 1 (R9).
    task automatic run_frame(input logic [15:0] st, input logic [15:0] off,
                             input int split, input bit lock, input int nlines,
                             input int width, input bit late_write);
        logic [15:0] base;
        bit          low;
        start_addr = st; row_offset = off; split_line = split[LINE_W-1:0]; pan_lock = lock;
        @(negedge clk); frame_start = 1'b1; disp_en = 1'b0; line_end = 1'b0;
        @(negedge clk); frame_start = 1'b0;
        base = (split == 0) ? 16'h0 : st;
        low  = (split == 0);
        chk(mem_addr == base, "R2 frame open addr", mem_addr, base);
        chk(lower_active == low, (split == 0) ? "R6 lower at top" : "R2 upper at open",
            lower_active, low);
        for (int ln = 0; ln < nlines; ln++) begin
            if (ln > 0) begin
                if (ln == split) begin base = 16'h0; low = 1'b1; end
                else if (!low || ln != split) base = base + off;
            end
            if (late_write && ln == 2) begin
                split_line = 11'd1; start_addr = 16'hAAAA;
            end
            for (int k = 0; k < width; k++) begin
                @(negedge clk); disp_en = 1'b1;
                chk(mem_addr == base + 16'(k), "R3 R4 char addr", mem_addr, base + 16'(k));
                if (k == 0) begin
                    chk(lower_active == low, low ? "R5 lower region" : "R7 R9 upper region",
                        lower_active, low);
                    chk(pan_out == ((low && lock) ? 4'd0 : pan_in), "R8 pan",
                        pan_out, (low && lock) ? 0 : pan_in);
                end
            end
            @(negedge clk); disp_en = 1'b0;
            chk(mem_addr == base + 16'(width), "R3 last step", mem_addr, base + 16'(width));
            @(negedge clk);
            chk(mem_addr == base + 16'(width), "R3 blank hold", mem_addr, base + 16'(width));
            line_end = 1'b1;
            @(negedge clk); line_end = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk(mem_addr == 16'h0, "R1 reset addr", mem_addr, 0);
        chk(lower_active == 1'b0, "R1 reset lower", lower_active, 0);
        chk(pan_out == pan_in, "R1 reset pan", pan_out, pan_in);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_addr == 16'h0, "R1 after reset addr", mem_addr, 0);
        chk(pan_out == pan_in, "R1 after reset pan", pan_out, pan_in);
    endtask

    task automatic t_split_unlocked();
        run_frame(16'h1000, 16'h0028, 3, 1'b0, 6, 4, 1'b0);
    endtask

    task automatic t_split_locked();
        run_frame(16'h1200, 16'h0028, 2, 1'b1, 5, 4, 1'b0);
        // next frame without split: pan released (R8)
        run_frame(16'h1200, 16'h0028, 40, 1'b1, 2, 3, 1'b0);
    endtask

    task automatic t_no_split();
        run_frame(16'h0400, 16'h0010, 20, 1'b1, 6, 3, 1'b0);
    endtask

    task automatic t_split_top();
        run_frame(16'h3000, 16'h0020, 0, 1'b1, 3, 3, 1'b0);
    endtask

    task automatic t_wrap();
        run_frame(16'hFFF0, 16'h0008, 30, 1'b0, 4, 4, 1'b0);
        run_frame(16'hFFFE, 16'h0000, 30, 1'b0, 1, 4, 1'b0);
    endtask

    task automatic t_late_write();
        run_frame(16'h2000, 16'h0030, 4, 1'b0, 6, 3, 1'b1);
        // new values captured now: split at 1, start 0xAAAA
        run_frame(16'hAAAA, 16'h0030, 1, 1'b0, 3, 3, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_split_unlocked();
        t_split_locked();
        t_no_split();
        t_split_top();
        t_wrap();
        t_late_write();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule